// File: doc/BRIEF.md
# Parameterized Microprogram Sequencer

This block is the control unit of a microcoded engine. It holds the address of the current microinstruction, reads the matching 64-bit word from a fixed microcode ROM and splits that word into a sequencing part and a datapath part. The sequencing part has three fields: a 4-bit test selector, a "then" target and an "else" target. Each cycle the selector picks one of sixteen conditions, where one entry is constant true, one is constant false and fourteen come from the datapath. The outcome chooses one of the two targets. The chosen target then sets the next microaddress.

A target byte either names a sequencing action or is itself a jump address. The actions are:
- step forward;
- hold the current address;
- return through an eight-entry return stack;
- dispatch through a mapping function that turns a 9-bit opcode into an entry point.

Every jump is also a call: it saves the address that follows it on the return stack. The remaining 44 bits of the word drive the datapath. The else byte is also brought out as a literal byte, which the datapath can use as a trace character.

Top module: `useq_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `uaddr` to 0x00, presents the word stored at address 0x00 on the outputs and empties the return stack. A later return with no call in between therefore lands on 0x00.
- R2: Bits [63:60] of the word select the condition. Value 0 always tests true and value 15 always tests false. A value k from 1 to 14 tests `cond_in[k-1]`.
- R3: When the tested condition is true, the next address comes from the then byte, bits [59:52]. Otherwise it comes from the else byte, bits [51:44].
- R4: Target 0xFC steps to `uaddr`+1 modulo 256, so 0xFF is followed by 0x00.
- R5: Target 0xFD keeps `uaddr` unchanged.
- R6: A target from 0x00 to 0xFB loads that value into `uaddr` and pushes `uaddr`+1 onto the return stack.
- R7: Target 0xFE loads the most recently pushed stack entry and removes it. On an empty stack it loads 0x00.
- R8: The return stack keeps the eight newest entries. A push onto a full stack discards the oldest entry.
- R9: Target 0xFF loads the dispatch address {`opcode[8]`^`opcode[7]`, `opcode[6:0]`}.
- R10: `ctrl_out` carries bits [43:0] of the current word and `trace_char` carries its else byte, bits [51:44].
- R11: `uaddr`, `ctrl_out` and `trace_char` all change on the same clock edge, one edge after the decision, and always describe the same word.
- R12: The ROM image is fixed and consists of the following entries:
  - Every word carries datapath bits {0xA, a, ~a, a^0x3C, a[3:0], a[7:4], a}, where a is its address.
  - Word 0x00 tests 1, with then = 0xFF and else = 0xFD.
  - Word 0xFF tests 0 and steps.
  - Words 0xC0 to 0xD2 test 0 and have else = 0xFC. Even addresses below 0xD2 jump to address+2, and the others return.
  - All other words test a[3:0].
    - Their then byte is chosen by a[5:4]: step, jump to (5a+16) mod 256 with bit 7 cleared when that value is 0xFC or above, return, or fork.
    - Their else byte is chosen by a[7:6]: hold, step, jump to a^0x55, or return. When a[3:0] is 15, the else byte is a step instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cond_in | input | 14 | Datapath conditions for selector values 1 to 14 |
| opcode | input | 9 | Opcode fed to the dispatch mapping |
| uaddr | output | 8 | Address of the current microinstruction |
| ctrl_out | output | 44 | Datapath control bits of the current word |
| trace_char | output | 8 | Else byte of the current word as a literal |

## Verification
The corner that is hardest to reach from the ports is the return stack at its limits. It must be pushed past eight entries and then drained past empty, and neither event is visible on any output until a return has already happened. The stimulus forks from address 0x00 into the call chain at 0xC0. There, nine calls in a row overflow the stack and nine returns in a row unwind the eight surviving entries and then pop the empty stack back to 0x00. A second pass resets the block halfway through that chain and then forces a return, which shows whether the reset really emptied the stack. Long runs with random conditions and opcodes then mix calls, returns, forks and holds, with both branches of every selector.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W  = 8;
  localparam int UW_W  = 64;
  localparam int SEL_W = 4;
  localparam int OPC_W = 9;
  localparam int EXT_N = (1 << SEL_W) - 2;
  localparam int DP_W  = UW_W - SEL_W - 2 * UA_W;

  localparam logic [UA_W-1:0] TGT_STEP   = 8'hFC;
  localparam logic [UA_W-1:0] TGT_HOLD   = 8'hFD;
  localparam logic [UA_W-1:0] TGT_RETURN = 8'hFE;
  localparam logic [UA_W-1:0] TGT_FORK   = 8'hFF;

  typedef enum logic [2:0] {
    ACT_STEP, ACT_HOLD, ACT_RETURN, ACT_FORK, ACT_JUMP
  } act_e;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [UA_W-1:0]  tgt_then;
    logic [UA_W-1:0]  tgt_else;
    logic [DP_W-1:0]  dp;
  } uword_t;

  function automatic act_e target_kind(input logic [UA_W-1:0] t);
    if (t == TGT_STEP)        return ACT_STEP;
    else if (t == TGT_HOLD)   return ACT_HOLD;
    else if (t == TGT_RETURN) return ACT_RETURN;
    else if (t == TGT_FORK)   return ACT_FORK;
    else                      return ACT_JUMP;
  endfunction

  function automatic logic [UA_W-1:0] step_addr(input logic [UA_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [UA_W-1:0] map_entry(input logic [OPC_W-1:0] op);
    return {op[8] ^ op[7], op[6:0]};
  endfunction

  function automatic logic [UA_W-1:0] call_target(input logic [UA_W-1:0] a);
    logic [UA_W-1:0] t;
    t = 8'(a * 8'd5 + 8'd16);
    if (t >= TGT_STEP) t = t & 8'h7F;
    return t;
  endfunction

  function automatic uword_t rom_word(input logic [UA_W-1:0] a);
    uword_t w;
    w.dp = {4'hA, a, ~a, a ^ 8'h3C, a[3:0], a[7:4], a};
    if (a == 8'h00) begin
      w.sel = 4'd1; w.tgt_then = TGT_FORK; w.tgt_else = TGT_HOLD;
    end else if (a == 8'hFF) begin
      w.sel = 4'd0; w.tgt_then = TGT_STEP; w.tgt_else = TGT_STEP;
    end else if (a >= 8'hC0 && a <= 8'hD2) begin
      w.sel = 4'd0;
      w.tgt_else = TGT_STEP;
      w.tgt_then = (!a[0] && a != 8'hD2) ? a + 8'd2 : TGT_RETURN;
    end else begin
      w.sel = a[3:0];
      case (a[5:4])
        2'd0:    w.tgt_then = TGT_STEP;
        2'd1:    w.tgt_then = call_target(a);
        2'd2:    w.tgt_then = TGT_RETURN;
        default: w.tgt_then = TGT_FORK;
      endcase
      case (a[7:6])
        2'd0:    w.tgt_else = TGT_HOLD;
        2'd1:    w.tgt_else = TGT_STEP;
        2'd2:    w.tgt_else = a ^ 8'h55;
        default: w.tgt_else = TGT_RETURN;
      endcase
      if (a[3:0] == 4'hF) w.tgt_else = TGT_STEP;
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_cond_mux.sv
module useq_cond_mux #(
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SW-1:0]        sel,
  input  logic [(1<<SW)-3:0]   ext,
  output logic                 hit
);
  localparam int N = 1 << SW;

  logic [N-1:0] vec;
  assign vec = {1'b0, ext, 1'b1};
  assign hit = vec[sel];

  // R2
  always_true_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> hit);
  // R2
  always_false_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == SW'(N - 1)) |-> !hit);
endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW-1:0] rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] wrap_dec(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign rp       = wrap_dec(wp);
  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign top_data = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      cnt <= '0;
    end else if (push) begin
      wp <= wrap_inc(wp);
      if (!full) cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      wp  <= rp;
      cnt <= cnt - 1'b1;
    end
  end

  // R8
  stack_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  // R6
  push_top_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> (top_data == $past(push_data)));
  // R7
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> empty);
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic [UA_W-1:0] upc,
  input  logic [UA_W-1:0] tgt,
  input  logic [UA_W-1:0] map_addr,
  input  logic [UA_W-1:0] pop_data,
  output logic [UA_W-1:0] nxt,
  output logic [UA_W-1:0] push_data,
  output act_e            act,
  output logic            push,
  output logic            pop
);
  always_comb begin
    act       = target_kind(tgt);
    push      = 1'b0;
    pop       = 1'b0;
    push_data = step_addr(upc);
    case (act)
      ACT_STEP:   nxt = step_addr(upc);
      ACT_HOLD:   nxt = upc;
      ACT_RETURN: begin nxt = pop_data; pop = 1'b1; end
      ACT_FORK:   nxt = map_addr;
      default:    begin nxt = tgt; push = 1'b1; end
    endcase
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXT_N-1:0] cond_in,
  input  logic [OPC_W-1:0] opcode,
  output logic [UA_W-1:0]  uaddr,
  output logic [DP_W-1:0]  ctrl_out,
  output logic [UA_W-1:0]  trace_char
);
  logic [UA_W-1:0] upc;
  uword_t          ir;
  logic            hit;
  logic [UA_W-1:0] tgt;
  logic [UA_W-1:0] map_addr;
  logic [UA_W-1:0] pop_data;
  logic [UA_W-1:0] push_data;
  logic [UA_W-1:0] nxt;
  act_e            act;
  logic            push;
  logic            pop;
  logic            stk_empty;
  logic            stk_full;
  uword_t          chk_w;

  useq_cond_mux #(.SW(SEL_W)) u_cond (
    .clk (clk),
    .rst (rst),
    .sel (ir.sel),
    .ext (cond_in),
    .hit (hit)
  );

  assign tgt      = hit ? ir.tgt_then : ir.tgt_else;
  assign map_addr = map_entry(opcode);

  useq_next_addr u_next (
    .upc       (upc),
    .tgt       (tgt),
    .map_addr  (map_addr),
    .pop_data  (pop_data),
    .nxt       (nxt),
    .push_data (push_data),
    .act       (act),
    .push      (push),
    .pop       (pop)
  );

  useq_ret_stack #(.W(UA_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .top_data  (pop_data),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upc <= '0;
      ir  <= rom_word('0);
    end else begin
      upc <= nxt;
      ir  <= rom_word(nxt);
    end
  end

  assign uaddr      = upc;
  assign ctrl_out   = ir.dp;
  assign trace_char = ir.tgt_else;
  assign chk_w      = rom_word(upc);

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_HOLD) |=> $stable(uaddr));
  // R4
  step_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_STEP) |=> (uaddr == UA_W'($past(uaddr) + 1'b1)));
  // R9
  fork_load_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_FORK) |=> (uaddr == $past(map_addr)));
  // R6
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_JUMP) |=> (uaddr == $past(tgt)));
  // R7
  empty_return_chk: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_RETURN && stk_empty) |=> (uaddr == '0));
  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && stk_full) |=> stk_full);
  // R11
  word_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_out == chk_w.dp) && (trace_char == chk_w.tgt_else));
endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] cond_in = '0;
  logic [8:0]  opcode = '0;
  logic [7:0]  uaddr;
  logic [43:0] ctrl_out;
  logic [7:0]  trace_char;

  useq_top u0 (
    .clk        (clk),
    .rst        (rst),
    .cond_in    (cond_in),
    .opcode     (opcode),
    .uaddr      (uaddr),
    .ctrl_out   (ctrl_out),
    .trace_char (trace_char)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int         q_due[$];
  logic [7:0] q_addr[$];
  string      q_tag[$];

  logic [7:0] m_pc;
  logic [7:0] m_stk [8];
  int         m_top;
  int         m_cnt;
  bit         m_lost;
  string      tag_pre = "";

  function automatic void check(string tg, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tg, got, exp);
    end
  endfunction

  // Program image restated from R12: {sel, then, else, datapath}
  function automatic logic [63:0] ref_word(input logic [7:0] a);
    logic [3:0] s; logic [7:0] th; logic [7:0] el; logic [43:0] d; logic [7:0] c;
    d = {4'hA, a, ~a, a ^ 8'h3C, a[3:0], a[7:4], a};
    s = a[3:0]; th = 8'hFC; el = 8'hFC;
    if (a == 8'h00) begin s = 4'd1; th = 8'hFF; el = 8'hFD; end
    else if (a == 8'hFF) begin s = 4'd0; end
    else if (a inside {[8'hC0:8'hD2]}) begin
      s = 4'd0;
      th = (a[0] == 1'b0 && a != 8'hD2) ? a + 8'd2 : 8'hFE;
    end else begin
      if (a[5:4] == 2'd1) begin
        c = 8'(a * 8'd5 + 8'd16);
        th = (c >= 8'hFC) ? {1'b0, c[6:0]} : c;
      end else if (a[5:4] == 2'd2) th = 8'hFE;
      else if (a[5:4] == 2'd3) th = 8'hFF;
      if (a[3:0] != 4'hF) begin
        if (a[7:6] == 2'd0) el = 8'hFD;
        else if (a[7:6] == 2'd2) el = a ^ 8'h55;
        else if (a[7:6] == 2'd3) el = 8'hFE;
      end
    end
    return {s, th, el, d};
  endfunction

  // Monitor: pops expected items once they fall due and compares them
  always @(negedge clk) begin
    logic [7:0]  a;
    logic [63:0] w;
    string       tg;
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      void'(q_due.pop_front());
      a  = q_addr.pop_front();
      tg = q_tag.pop_front();
      w  = ref_word(a);
      check({tg, " uaddr"}, {56'd0, uaddr}, {56'd0, a});
      check({tg, " R10 R11 ctrl_out"}, {20'd0, ctrl_out}, {20'd0, w[43:0]});
      check({tg, " R10 trace_char"}, {56'd0, trace_char}, {56'd0, w[51:44]});
    end
  end

  // Driver: applies inputs, predicts the next address and queues it
  task automatic step(input logic [13:0] c, input logic [8:0] op);
    logic [63:0] w; logic [3:0] s; bit h; logic [7:0] t; logic [7:0] n; string tg;
    cond_in = c; opcode = op;
    w = ref_word(m_pc);
    s = w[63:60];
    if (s == 4'd0) h = 1'b1;
    else if (s == 4'd15) h = 1'b0;
    else h = c[s - 1];
    t = h ? w[59:52] : w[51:44];
    if (t == 8'hFC) begin
      n = m_pc + 8'd1;
      tg = (m_pc == 8'hFF) ? "R4 wrap" : "R4";
    end else if (t == 8'hFD) begin
      n = m_pc; tg = "R5";
    end else if (t == 8'hFE) begin
      if (m_cnt == 0) begin n = 8'h00; tg = "R7 empty"; end
      else begin
        m_top = (m_top + 7) % 8;
        n = m_stk[m_top];
        m_cnt--;
        tg = m_lost ? "R8 R7" : "R7";
      end
    end else if (t == 8'hFF) begin
      n = {op[8] ^ op[7], op[6:0]}; tg = "R9";
    end else begin
      m_stk[m_top] = m_pc + 8'd1;
      m_top = (m_top + 1) % 8;
      if (m_cnt < 8) m_cnt++; else m_lost = 1'b1;
      n = t; tg = "R6";
    end
    tg = $sformatf("%s%s R2 sel=%0d R3 %s", tag_pre, tg, s, h ? "then" : "else");
    q_due.push_back(cyc + 1);
    q_addr.push_back(n);
    q_tag.push_back(tg);
    m_pc = n;
    @(negedge clk);
  endtask

  task automatic do_reset();
    logic [63:0] w;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    w = ref_word(8'h00);
    check("R1 reset uaddr", {56'd0, uaddr}, 64'd0);
    check("R1 reset ctrl_out", {20'd0, ctrl_out}, {20'd0, w[43:0]});
    check("R1 reset trace_char", {56'd0, trace_char}, {56'd0, w[51:44]});
    rst = 1'b0;
    m_pc = 8'h00; m_top = 0; m_cnt = 0; m_lost = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    do_reset();
    // R5: hub holds while its condition is low
    repeat (3) step(14'h0000, 9'h000);
    // R6 R8 R7: nine nested calls, then unwind through an empty stack
    step(14'h0001, 9'h0C0);
    repeat (30) step(14'h0000, 9'h000);
    // R4: wrap from 0xFF to 0x00
    step(14'h0001, 9'h0FF);
    step(14'h0000, 9'h000);
    // R9: opcode bit 8 folds into bit 7 of the entry address
    step(14'h0001, 9'h1C0);
    repeat (4) step(14'h3FFF, 9'h000);
    // R1: reset in the middle of the call chain empties the stack
    do_reset();
    step(14'h0001, 9'h0C0);
    repeat (3) step(14'h0000, 9'h000);
    do_reset();
    step(14'h0001, 9'h020);
    tag_pre = "R1 ";
    step(14'h0000, 9'h000);
    tag_pre = "";
    // Random conditions and opcodes
    repeat (3000) step(14'($urandom), 9'($urandom));
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule